// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This unit sits beside an instruction fetch stage and removes the loop-closing branch from software loops. Before entering a nest, software writes up to four loop descriptors. Each descriptor holds a trigger address (the last instruction of the body), a target address (where the next pass starts) and a pass count. A separate arm command turns each descriptor into an active loop. Loops are armed from the outermost to the innermost. After that, fetch runs straight ahead until the program counter reaches a trigger. From then on the controller decides in the same cycle whether the next fetch goes back to the target or falls through.

All counters are kept inside the unit. When an enclosing loop takes its branch back, every loop nested inside it is refilled with its own pass count. When the outermost loop finishes its last pass, the whole nest is retired. No instruction inside a body is spent on loop upkeep.

A small state machine tracks how full the loop stack is. It has three states. ST_EMPTY means no loop is active. ST_PARTIAL means one to three loops are active. ST_FULL means four loops are active. Transitions:
- arm: ST_EMPTY goes to ST_PARTIAL, and ST_PARTIAL goes to ST_FULL when the fourth loop arrives.
- retire: from ST_PARTIAL or ST_FULL, the state goes to ST_EMPTY.
- retire-and-arm: when a retirement and an arm happen in the same cycle, the state goes to ST_PARTIAL.

Top module: `zol_ctrl`

## Requirements
- R1: After reset no loop is active: `redirect`, `loop_busy`, `loop_full` and `arm_overflow` are all 0.
- R2: A configuration write with `cfg_op` = 0 stages a trigger address, 1 stages a target address and 2 stages a pass count. `cfg_op` = 3 arms the staged loop as the new innermost active loop, and `loop_busy` is 1 from the next cycle on.
- R3: An arm while four loops are active is ignored. It sets `arm_overflow`, which stays 1 until reset, and the ignored loop never causes a redirect.
- R4: When `fetch_valid` is 1 and `fetch_pc` equals the trigger of an active loop that still has passes remaining, `redirect` is 1 in that same cycle and `redirect_pc` equals that loop's target. Otherwise `redirect` is 0 and fetch continues at `fetch_pc`+1.
- R5: A pass count of N gives exactly N passes through the body. A count of 0 gives one pass.
- R6: Each time a loop branches back, every loop nested inside it is refilled with its full pass count.
- R7: When several active loops share a trigger, the innermost one decides first. If its passes are used up, the next enclosing loop with that trigger decides in the same cycle.
- R8: When the outermost loop finishes its last pass, all loops are retired and `loop_busy` returns to 0.
- R9: `loop_busy` is 1 while at least one loop is active. `loop_full` is 1 exactly when four loops are active.
- R10: While `fetch_valid` is 0 there is no redirect, and no pass is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 trigger, 1 target, 2 pass count, 3 arm |
| cfg_data | input | ADDR_W | Address or count value (the count uses the low CNT_W bits) |
| fetch_valid | input | 1 | `fetch_pc` is being fetched this cycle |
| fetch_pc | input | ADDR_W | Current fetch address |
| redirect | output | 1 | The next fetch must go to `redirect_pc` |
| redirect_pc | output | ADDR_W | Loop target address |
| loop_busy | output | 1 | At least one loop is active |
| loop_full | output | 1 | Loop stack is full |
| arm_overflow | output | 1 | Sticky flag: an arm was rejected |

## Verification
A wrong pass counter or a missed refill of an inner loop does not show at once. It shows at the next visit to that loop's trigger, as a redirect that is missing or extra. It therefore surfaces within one body length, and the bench catches it by comparing every fetched address against a trace built from plain nested loops. A depth that is not retired shows on `loop_busy` the cycle after the outermost loop's final trigger. An error in the shared-trigger fall-through shows as a wrong `redirect_pc` at that shared address.

// File: rtl/zol_pkg.sv
package zol_pkg;
    typedef enum logic [1:0] {
        CFG_TRIG = 2'd0,
        CFG_TGT  = 2'd1,
        CFG_CNT  = 2'd2,
        CFG_ARM  = 2'd3
    } cfg_op_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_e;
endpackage

// File: rtl/zol_match.sv
module zol_match #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int SLOTS  = 4,
    parameter int IDX_W  = 3,
    parameter int SEL_W  = 2
) (
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [IDX_W-1:0]  depth,
    input  logic [ADDR_W-1:0] trig [SLOTS],
    input  logic [CNT_W-1:0]  left [SLOTS],
    output logic              hit,
    output logic [SEL_W-1:0]  hit_idx,
    output logic [SLOTS-1:0]  expire,
    output logic              clear_all
);
    // Scan from innermost to outermost; exhausted loops fall through to the next one.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        expire  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!hit && fetch_valid && (IDX_W'(i) < depth) && (fetch_pc == trig[i])) begin
                if (left[i] > CNT_W'(1)) begin
                    hit     = 1'b1;
                    hit_idx = SEL_W'(i);
                end else begin
                    expire[i] = 1'b1;
                end
            end
        end
    end

    assign clear_all = expire[0];
endmodule

// File: rtl/zol_depth_fsm.sv
module zol_depth_fsm import zol_pkg::*; #(
    parameter int SLOTS = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_req,
    input  logic             clear_all,
    output logic             arm_accept,
    output logic [IDX_W-1:0] depth,
    output logic             busy,
    output logic             full,
    output logic             overflow
);
    occ_e             state_q, state_n;
    logic [IDX_W-1:0] depth_n;

    assign arm_accept = arm_req && (clear_all || (depth != IDX_W'(SLOTS)));

    always_comb begin
        depth_n = clear_all ? '0 : depth;
        if (arm_accept) depth_n = depth_n + IDX_W'(1);
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_EMPTY:   if (arm_accept)
                            state_n = (depth_n == IDX_W'(SLOTS)) ? ST_FULL : ST_PARTIAL;
            ST_PARTIAL: if (depth_n == '0)              state_n = ST_EMPTY;
                        else if (depth_n == IDX_W'(SLOTS)) state_n = ST_FULL;
            ST_FULL:    if (clear_all)
                            state_n = arm_accept ? ST_PARTIAL : ST_EMPTY;
            default:    state_n = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            depth    <= '0;
            overflow <= 1'b0;
        end else begin
            state_q  <= state_n;
            depth    <= depth_n;
            overflow <= overflow | (arm_req & ~arm_accept);
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY:   begin busy = 1'b0; full = 1'b0; end
            ST_PARTIAL: begin busy = 1'b1; full = 1'b0; end
            ST_FULL:    begin busy = 1'b1; full = 1'b1; end
            default:    begin busy = 1'b0; full = 1'b0; end
        endcase
    end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl import zol_pkg::*; #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_op,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              loop_busy,
    output logic              loop_full,
    output logic              arm_overflow
);
    localparam int IDX_W = $clog2(SLOTS + 1);
    localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [ADDR_W-1:0] stg_trig, stg_tgt;
    logic [CNT_W-1:0]  stg_cnt;
    logic [ADDR_W-1:0] trig_q [SLOTS];
    logic [ADDR_W-1:0] tgt_q  [SLOTS];
    logic [CNT_W-1:0]  init_q [SLOTS];
    logic [CNT_W-1:0]  left_q [SLOTS];

    logic [IDX_W-1:0]  depth, push_slot;
    logic [SEL_W-1:0]  hit_idx;
    logic [SLOTS-1:0]  expire;
    logic              hit, clear_all, arm_req, arm_accept;
    logic [CNT_W-1:0]  stg_passes;

    assign arm_req    = cfg_valid && (cfg_op_e'(cfg_op) == CFG_ARM);
    assign push_slot  = clear_all ? '0 : depth;
    assign stg_passes = (stg_cnt == '0) ? CNT_W'(1) : stg_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_trig <= '0;
            stg_tgt  <= '0;
            stg_cnt  <= '0;
        end else if (cfg_valid) begin
            unique case (cfg_op_e'(cfg_op))
                CFG_TRIG: stg_trig <= cfg_data;
                CFG_TGT:  stg_tgt  <= cfg_data;
                CFG_CNT:  stg_cnt  <= cfg_data[CNT_W-1:0];
                CFG_ARM:  ;
                default:  ;
            endcase
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                trig_q[s] <= '0;
                tgt_q[s]  <= '0;
                init_q[s] <= '0;
                left_q[s] <= '0;
            end else if (arm_accept && (push_slot == IDX_W'(s))) begin
                trig_q[s] <= stg_trig;
                tgt_q[s]  <= stg_tgt;
                init_q[s] <= stg_passes;
                left_q[s] <= stg_passes;
            end else if (hit && (IDX_W'(hit_idx) == IDX_W'(s))) begin
                left_q[s] <= left_q[s] - CNT_W'(1);
            end else if (hit && (IDX_W'(s) > IDX_W'(hit_idx))) begin
                left_q[s] <= init_q[s];
            end else if (expire[s]) begin
                left_q[s] <= '0;
            end
        end
    end

    zol_match #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOTS(SLOTS), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) i_match (
        .fetch_valid(fetch_valid),
        .fetch_pc   (fetch_pc),
        .depth      (depth),
        .trig       (trig_q),
        .left       (left_q),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .expire     (expire),
        .clear_all  (clear_all)
    );

    zol_depth_fsm #(.SLOTS(SLOTS), .IDX_W(IDX_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_req   (arm_req),
        .clear_all (clear_all),
        .arm_accept(arm_accept),
        .depth     (depth),
        .busy      (loop_busy),
        .full      (loop_full),
        .overflow  (arm_overflow)
    );

    assign redirect    = hit;
    assign redirect_pc = hit ? tgt_q[hit_idx] : '0;
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_valid,
    input logic [1:0] cfg_op,
    input logic       fetch_valid,
    input logic       redirect,
    input logic       loop_busy,
    input logic       loop_full,
    input logic       arm_overflow
);
    p_redirect_needs_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> fetch_valid);

    p_redirect_needs_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> loop_busy);

    p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_overflow |=> arm_overflow);

    p_overflow_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_overflow) |-> $past(cfg_valid && cfg_op == 2'd3 && loop_full));

    p_full_is_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_full |-> loop_busy);

    p_arm_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_op == 2'd3) |=> loop_busy);

    p_quiet_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !cfg_valid) |=> ($stable(loop_busy) && $stable(loop_full)));
endmodule

bind zol_ctrl zol_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid   (cfg_valid),
    .cfg_op      (cfg_op),
    .fetch_valid (fetch_valid),
    .redirect    (redirect),
    .loop_busy   (loop_busy),
    .loop_full   (loop_full),
    .arm_overflow(arm_overflow)
);

// File: tb/test_zol_ctrl.sv
module test_zol_ctrl;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [1:0]    cfg_op = 2'd0;
    logic [AW-1:0] cfg_data = '0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          redirect, loop_busy, loop_full, arm_overflow;
    logic [AW-1:0] redirect_pc;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    zol_ctrl i_zol_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
        .cfg_data(cfg_data), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .redirect(redirect), .redirect_pc(redirect_pc), .loop_busy(loop_busy),
        .loop_full(loop_full), .arm_overflow(arm_overflow)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] op, input int d);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_op    = op;
        cfg_data  = AW'(d);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic arm(input int trig, input int tgt, input int cnt);
        cfg(2'd0, trig);
        cfg(2'd1, tgt);
        cfg(2'd2, cnt);
        cfg(2'd3, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fetch_valid = 1'b0;
        cfg_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Follow the design's fetch path and compare every fetched address to the expected trace.
    task automatic run_trace(input int start, input int exp_q[$], input string req);
        int pc = start;
        foreach (exp_q[k]) begin
            @(negedge clk);
            fetch_valid = 1'b1;
            fetch_pc = AW'(pc);
            #2;
            chk(req, "fetched pc", pc, exp_q[k]);
            pc = redirect ? int'(redirect_pc) : pc + 1;
        end
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    function automatic void add_range(ref int q[$], input int lo, input int hi);
        for (int a = lo; a <= hi; a++) q.push_back(a);
    endfunction

    initial begin
        int q[$];
        void'($urandom(32'd20240611));

        do_reset();
        #2;
        // R1: reset state
        chk("R1", "redirect", redirect, 0);
        chk("R1", "loop_busy", loop_busy, 0);
        chk("R1", "loop_full", loop_full, 0);
        chk("R1", "arm_overflow", arm_overflow, 0);

        // R2 R5 R6 R8: three-deep nest, outer 2 / middle 2 / inner 4
        arm(18, 10, 2);
        arm(16, 12, 2);
        arm(14, 12, 4);
        #2 chk("R2", "loop_busy after arm", loop_busy, 1);
        chk("R9", "loop_full with three", loop_full, 0);
        q.delete();
        q.push_back(8); q.push_back(9);
        for (int o = 0; o < 2; o++) begin
            add_range(q, 10, 11);
            for (int m = 0; m < 2; m++) begin
                for (int i = 0; i < 4; i++) add_range(q, 12, 14);
                add_range(q, 15, 16);
            end
            add_range(q, 17, 18);
        end
        add_range(q, 19, 20);
        run_trace(8, q, "R6");
        #2 chk("R8", "loop_busy after nest", loop_busy, 0);

        // R7: shared trigger, inner 3 passes, outer 2
        arm(46, 40, 2);
        arm(46, 44, 3);
        q.delete();
        for (int o = 0; o < 2; o++) begin
            add_range(q, 40, 43);
            for (int i = 0; i < 3; i++) add_range(q, 44, 46);
        end
        q.push_back(47);
        run_trace(40, q, "R7");
        #2 chk("R8", "loop_busy after shared", loop_busy, 0);

        // R5: count zero gives one pass
        arm(500, 495, 0);
        q.delete();
        add_range(q, 495, 501);
        run_trace(495, q, "R5");
        #2 chk("R5", "loop_busy after zero count", loop_busy, 0);

        // R10: an idle fetch slot at the trigger neither redirects nor counts
        arm(300, 290, 3);
        @(negedge clk);
        fetch_valid = 1'b0;
        fetch_pc = AW'(300);
        #2 chk("R10", "redirect while idle", redirect, 0);
        q.delete();
        for (int i = 0; i < 3; i++) add_range(q, 290, 300);
        q.push_back(301);
        run_trace(290, q, "R10");

        // R4 R5: random single loops against plain software loops
        for (int r = 0; r < 12; r++) begin
            int tgt = 100 + int'($urandom_range(0, 100));
            int len = int'($urandom_range(0, 5));
            int cnt = int'($urandom_range(0, 5));
            int passes = (cnt == 0) ? 1 : cnt;
            arm(tgt + len, tgt, cnt);
            q.delete();
            for (int p = 0; p < passes; p++) add_range(q, tgt, tgt + len);
            q.push_back(tgt + len + 1);
            run_trace(tgt, q, "R4");
            #2 chk("R8", "loop_busy after random loop", loop_busy, 0);
        end

        // R3 R9: fill the stack, then a rejected fifth arm
        for (int k = 0; k < 4; k++) arm(1000 + k, 900, 3);
        #2 chk("R9", "loop_full with four", loop_full, 1);
        chk("R3", "arm_overflow before fifth", arm_overflow, 0);
        arm(2000, 1900, 3);
        #2 chk("R3", "arm_overflow after fifth", arm_overflow, 1);
        chk("R9", "loop_full after fifth", loop_full, 1);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_pc = AW'(2000);
        #2 chk("R3", "redirect at rejected trigger", redirect, 0);
        @(negedge clk);
        fetch_valid = 1'b0;
        repeat (3) @(negedge clk);
        #2 chk("R3", "arm_overflow stays", arm_overflow, 1);
        do_reset();
        #2 chk("R1", "arm_overflow cleared", arm_overflow, 0);
        chk("R1", "loop_full cleared", loop_full, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule